// File: doc/BRIEF.md
# Nonvolatile Store Sequencer

This block holds a set of working channel values and a matching set of backing values that stand in for nonvolatile storage. A serial front end hands over each received frame as a one-cycle done strobe with a channel address and a data byte. Every accepted frame updates the addressed working value at once. It becomes a permanent store only when the program request line is raised inside a narrow window of that frame. The window opens after the start bit and closes at the serial clock edge that follows the last data bit.

A store that is accepted drives the ready flag low for a fixed number of serial clock ticks. While the store runs the block ignores new frames and turns off the serial data output enable. The backing value of the addressed channel is written on the last busy tick. A supply-good input can veto the store, in which case the ready flag never drops and nothing is written. A separate power-up strobe copies every backing value into the working values in one system clock cycle, with no serial tick needed. Serial clock edges arrive as one-cycle tick pulses on the system clock, so the write time is counted in serial ticks.

Top module: `nvm_store_seq`

## Requirements
- R1: A frame done strobe while ready writes data_i into the working value of channel addr_i (channel k at address k, working byte k at work_o[8k+7:8k]); it is visible one clock later.
- R2: A store is accepted only if prog_i is high on the first serial tick after frame done and prog_i was low when the start pulse arrived; a request raised after that tick or already high at the start pulse is ignored: rdy_o stays high and no backing value changes.
- R3: After an accepted store, rdy_o is low from the next clock and stays low for exactly WR_TICKS serial ticks, rising after the WR_TICKS-th tick.
- R4: The backing value of the addressed channel takes the frame data on the same edge where rdy_o rises; the other backing values are unchanged.
- R5: If supply_ok_i is low on the sampling tick, rdy_o stays high and no backing value changes.
- R6: While busy, a frame done strobe leaves every working value unchanged, and do_en_o is low.
- R7: A store of a value equal to the backing value still keeps rdy_o low for the full WR_TICKS ticks.
- R8: A one-cycle pwrup_i pulse loads every working value from its backing value by the next clock, with no serial tick.
- R9: After reset all working and backing values equal BACK_INIT, and rdy_o and do_en_o are high.
- R10: Busy time advances only on serial ticks; with no ticks rdy_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwrup_i | input | 1 | Power-up load strobe |
| sclk_tick_i | input | 1 | One pulse per serial clock rising edge |
| start_i | input | 1 | Pulse with the tick that took the start bit |
| frame_done_i | input | 1 | Pulse with the tick that took the last data bit |
| addr_i | input | AW | Channel address of the frame |
| data_i | input | DW | Data byte of the frame |
| prog_i | input | 1 | Program request |
| supply_ok_i | input | 1 | Supply high enough to program |
| rdy_o | output | 1 | Ready, low while a store runs |
| do_en_o | output | 1 | Serial data output enable |
| work_o | output | N_CH*DW | Working values, channel 0 in the low byte |
| back_o | output | N_CH*DW | Backing values, channel 0 in the low byte |

## Verification
The hardest states to reach are the window edges. The bench has to tell a request raised just after the sampling tick from one raised inside the window, and a level already high at the start pulse from one that rose later. Its frame task places the prog edge at a chosen tick relative to the start and done pulses. That gives early, in-window and late cases in otherwise identical frames. A busy period is then held open by pausing the ticks, so the bench can show that the write waits for the serial clock and that a frame arriving mid-store has no effect.

// File: rtl/nvm_store_pkg.sv
package nvm_store_pkg;
  localparam int unsigned DEF_N_CH     = 4;
  localparam int unsigned DEF_DW       = 8;
  localparam int unsigned DEF_WR_TICKS = 16;
endpackage

// File: rtl/nvm_store_window.sv
module nvm_store_window #(
  parameter int unsigned N_CH = nvm_store_pkg::DEF_N_CH,
  parameter int unsigned DW   = nvm_store_pkg::DEF_DW,
  localparam int unsigned AW  = $clog2(N_CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_tick_i,
  input  logic          start_i,
  input  logic          frame_done_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          prog_i,
  input  logic          supply_ok_i,
  input  logic          busy_i,
  output logic          go_o,
  output logic [AW-1:0] st_addr_o,
  output logic [DW-1:0] st_data_o
);
  logic prog_early_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_early_q <= 1'b0;
      armed_q      <= 1'b0;
      st_addr_o    <= '0;
      st_data_o    <= '0;
    end else begin
      if (start_i) prog_early_q <= prog_i;
      if (frame_done_i && !busy_i) begin
        armed_q   <= 1'b1;
        st_addr_o <= addr_i;
        st_data_o <= data_i;
      end else if (sclk_tick_i) begin
        armed_q <= 1'b0;  // window closes on the tick after the last bit
      end
    end
  end

  assign go_o = armed_q && sclk_tick_i && prog_i && !prog_early_q && supply_ok_i && !busy_i;
endmodule

// File: rtl/nvm_store_timer.sv
module nvm_store_timer #(
  parameter int unsigned WR_TICKS = nvm_store_pkg::DEF_WR_TICKS,
  localparam int unsigned CW      = $clog2(WR_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_tick_i,
  input  logic go_i,
  output logic busy_o,
  output logic done_o
);
  localparam logic [CW-1:0] LAST = CW'(WR_TICKS - 1);
  logic [CW-1:0] cnt_q;

  assign done_o = busy_o && sclk_tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (go_i) begin
      busy_o <= 1'b1;
      cnt_q  <= '0;
    end else if (done_o) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_o && sclk_tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r10_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !sclk_tick_i |=> busy_o && $stable(cnt_q));
  a_r3_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cnt_q <= LAST);
endmodule

// File: rtl/nvm_store_bank.sv
module nvm_store_bank #(
  parameter int unsigned N_CH        = nvm_store_pkg::DEF_N_CH,
  parameter int unsigned DW          = nvm_store_pkg::DEF_DW,
  parameter logic [DW-1:0] BACK_INIT = '0,
  localparam int unsigned AW         = $clog2(N_CH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwrup_i,
  input  logic               busy_i,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic               st_en_i,
  input  logic [AW-1:0]      st_addr_i,
  input  logic [DW-1:0]      st_data_i,
  output logic [N_CH*DW-1:0] work_o,
  output logic [N_CH*DW-1:0] back_o
);
  logic [DW-1:0] work_q [N_CH];
  logic [DW-1:0] back_q [N_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_CH; i++) begin
        work_q[i] <= BACK_INIT;
        back_q[i] <= BACK_INIT;
      end
    end else begin
      for (int i = 0; i < N_CH; i++)
        if (st_en_i && st_addr_i == AW'(i)) back_q[i] <= st_data_i;
      if (pwrup_i) begin
        for (int i = 0; i < N_CH; i++) work_q[i] <= back_q[i];
      end else if (wr_en_i) begin
        work_q[wr_addr_i] <= wr_data_i;
      end
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_flat
    assign work_o[g*DW +: DW] = work_q[g];
    assign back_o[g*DW +: DW] = back_q[g];
  end

  a_r4_backing_moves_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(back_o) |-> $fell(busy_i));
  a_r8_pwrup_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pwrup_i) |-> work_o == $past(back_o));
  a_r6_work_frozen_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_i) && !$past(pwrup_i) |-> $stable(work_o));
endmodule

// File: rtl/nvm_store_seq.sv
module nvm_store_seq #(
  parameter int unsigned N_CH        = nvm_store_pkg::DEF_N_CH,
  parameter int unsigned DW          = nvm_store_pkg::DEF_DW,
  parameter int unsigned WR_TICKS    = nvm_store_pkg::DEF_WR_TICKS,
  parameter logic [DW-1:0] BACK_INIT = DW'(8'h80),
  localparam int unsigned AW         = $clog2(N_CH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwrup_i,
  input  logic               sclk_tick_i,
  input  logic               start_i,
  input  logic               frame_done_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      data_i,
  input  logic               prog_i,
  input  logic               supply_ok_i,
  output logic               rdy_o,
  output logic               do_en_o,
  output logic [N_CH*DW-1:0] work_o,
  output logic [N_CH*DW-1:0] back_o
);
  logic busy, go, done;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;

  nvm_store_window #(.N_CH(N_CH), .DW(DW)) u_window (
    .clk_i, .rst_ni, .sclk_tick_i, .start_i, .frame_done_i, .addr_i, .data_i,
    .prog_i, .supply_ok_i, .busy_i(busy), .go_o(go),
    .st_addr_o(st_addr), .st_data_o(st_data)
  );

  nvm_store_timer #(.WR_TICKS(WR_TICKS)) u_timer (
    .clk_i, .rst_ni, .sclk_tick_i, .go_i(go), .busy_o(busy), .done_o(done)
  );

  nvm_store_bank #(.N_CH(N_CH), .DW(DW), .BACK_INIT(BACK_INIT)) u_bank (
    .clk_i, .rst_ni, .pwrup_i, .busy_i(busy),
    .wr_en_i(frame_done_i && !busy), .wr_addr_i(addr_i), .wr_data_i(data_i),
    .st_en_i(done), .st_addr_i(st_addr), .st_data_i(st_data),
    .work_o, .back_o
  );

  assign rdy_o   = !busy;
  assign do_en_o = !busy;

  a_r5_busy_needs_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) |-> $past(supply_ok_i));
  a_r2_busy_from_prog_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) |-> $past(sclk_tick_i && prog_i));
endmodule

// File: tb/nvm_store_seq_bench.sv
module nvm_store_seq_bench;
  localparam int WR = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pwrup = 0, sclk = 0, start = 0, fd = 0, prog = 0, sup = 1;
  logic [1:0] addr = '0;
  logic [7:0] data = '0;
  logic rdy, do_en;
  logic [31:0] work, back;
  int errors = 0, checks = 0;
  bit finished = 0;
  logic [7:0] ew [4];
  logic [7:0] eb [4];

  always #5 clk = ~clk;

  nvm_store_seq u_nvm_store_seq (
    .clk_i(clk), .rst_ni(rst_n), .pwrup_i(pwrup), .sclk_tick_i(sclk), .start_i(start),
    .frame_done_i(fd), .addr_i(addr), .data_i(data), .prog_i(prog), .supply_ok_i(sup),
    .rdy_o(rdy), .do_en_o(do_en), .work_o(work), .back_o(back)
  );

  localparam logic [9:0] VEC [6] = '{
    {2'd0, 8'h11}, {2'd1, 8'h22}, {2'd2, 8'h33},
    {2'd3, 8'h44}, {2'd0, 8'h00}, {2'd3, 8'hFF}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int k = 0; k < 4; k++) begin
      chk(req, 32'(work[k*8 +: 8]), 32'(ew[k]));
      chk(req, 32'(back[k*8 +: 8]), 32'(eb[k]));
    end
  endtask

  task automatic tick();
    @(negedge clk); sclk = 1;
    @(negedge clk); sclk = 0;
  endtask

  // mode: 0 no prog, 1 in window, 2 high at start, 3 raised after sample tick
  task automatic frame(input logic [1:0] a, input logic [7:0] d, input int mode);
    @(negedge clk); start = 1; sclk = 1; prog = (mode == 2);
    @(negedge clk); start = 0; sclk = 0;
    tick();
    if (mode == 1) prog = 1;
    tick();
    @(negedge clk); fd = 1; sclk = 1; addr = a; data = d;
    @(negedge clk); fd = 0; sclk = 0;
    tick();
    if (mode == 3) begin prog = 1; tick(); end
    prog = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin ew[k] = 8'h80; eb[k] = 8'h80; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 rdy", 32'(rdy), 1); chk("R9 do_en", 32'(do_en), 1);
    chk_all("R9 reset values");

    foreach (VEC[i]) begin
      frame(VEC[i][9:8], VEC[i][7:0], 0);
      ew[VEC[i][9:8]] = VEC[i][7:0];
      chk("R1 volatile write", 32'(work[VEC[i][9:8]*8 +: 8]), 32'(VEC[i][7:0]));
    end
    chk_all("R1 table end");

    frame(2'd1, 8'h5C, 3); ew[1] = 8'h5C;
    chk("R2 late prog rdy", 32'(rdy), 1);
    repeat (WR + 2) tick();
    chk_all("R2 late prog no store");

    frame(2'd1, 8'h6D, 2); ew[1] = 8'h6D;
    chk("R2 early prog rdy", 32'(rdy), 1);
    repeat (WR + 2) tick();
    chk_all("R2 early prog no store");

    frame(2'd2, 8'hA5, 1); ew[2] = 8'hA5;
    chk("R3 busy after accept", 32'(rdy), 0);
    chk("R6 do_en low", 32'(do_en), 0);
    @(negedge clk); fd = 1; sclk = 1; addr = 2'd0; data = 8'hEE;
    @(negedge clk); fd = 0; sclk = 0;
    chk_all("R6 frame ignored while busy");
    repeat (40) @(negedge clk);
    chk("R10 no tick keeps busy", 32'(rdy), 0);
    repeat (WR - 2) tick();
    chk("R3 busy before last tick", 32'(rdy), 0);
    chk("R4 backing not yet written", 32'(back[23:16]), 32'h80);
    tick(); eb[2] = 8'hA5;
    chk("R3 ready after last tick", 32'(rdy), 1);
    chk_all("R4 store addressed channel only");

    sup = 0;
    frame(2'd1, 8'h77, 1); ew[1] = 8'h77;
    chk("R5 low supply rdy", 32'(rdy), 1);
    repeat (WR + 2) tick();
    chk("R5 low supply rdy later", 32'(rdy), 1);
    chk_all("R5 no store");
    sup = 1;

    frame(2'd2, 8'hA5, 1);
    chk("R7 equal value busy", 32'(rdy), 0);
    repeat (WR - 1) tick();
    chk("R7 still busy", 32'(rdy), 0);
    tick();
    chk("R7 ready after full time", 32'(rdy), 1);
    chk_all("R7 values");

    @(negedge clk); pwrup = 1;
    @(negedge clk); pwrup = 0;
    for (int k = 0; k < 4; k++) ew[k] = eb[k];
    chk_all("R8 power-up load");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule